// File: doc/BRIEF.md
# ADC Register Window with Synthetic Sampler

This block is the register file of an analog-to-digital converter peripheral, seen as a 256-byte window of 32-bit words. It keeps control, sample-time, threshold, sequence, status, injected-offset and injected-data words, plus a regular result register. No converter is modelled. Each triggered read of the result register makes a synthetic sample instead. The sample is the previous stored result plus a fixed step. It is truncated to the resolution chosen in the first control word and can be returned left-aligned.

The bus side has one read channel and one write channel, and each channel takes one cycle. Read data is combinational from the read address in the cycle `rd_en` is high. State changes at the next rising clock edge. Both channels can be active in the same cycle.

Top module: `adc_reg_window`

## Requirements
- R1: After reset every word reads 0, except the high-threshold word (offset 0x24), which reads 0x00000FFF.
- R2: A read of the result word (offset 0x4C) while bit 0 (enable) and bit 30 (start) of control word B (offset 0x08) are both 1 returns a new sample and clears the start bit at the same clock edge. A second result read with no new start therefore returns 0.
- R3: A result read while enable or start is 0 returns 0 and leaves the stored sample unchanged.
- R4: The new stored sample is (old stored sample + 7) masked by the resolution field, bits 25:24 of control word A (offset 0x04). The field values 0, 1, 2 and 3 keep 12, 10, 8 and 6 bits, so the sample wraps at those widths.
- R5: When bit 11 of control word B is 1, the returned sample is (stored sample << 1) & 0xFFF0. When bit 11 is 0, the stored sample is returned unchanged.
- R6: A write to the status word (offset 0x00) sets it to old status AND the low 6 bits of the write data. Bits 31:6 always read 0.
- R7: A read of control word B returns only bits 27:0. Bits 31:28 read as 0.
- R8: Writes to the four injected-offset words (0x14, 0x18, 0x1C, 0x20) keep only bits 11:0.
- R9: Writes to injected-data word n (0x3C, 0x40, 0x44, 0x48) store all 32 bits. A read of it returns the stored data minus injected offset n, modulo 2^32.
- R10: Reads of unmapped or non-word-aligned offsets return 0. Writes to them, and to the result word, change nothing.
- R11: When a control word B write and a triggered result read fall in the same cycle, the written value wins over the automatic clearing of the start bit.
- R12: Control word A, the two sample-time words (0x0C, 0x10), both threshold words (0x24, 0x28), the three sequence words (0x2C, 0x30, 0x34) and the injected sequence word (0x38) store and return all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, valid in the strobe cycle |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |

## Verification
The assertions take for granted that reset is held for at least one clock edge, and that the read and write strobes are never unknown once reset is released. The same-cycle property assumes that a read and a write may overlap only in the way the bus allows, with one address per channel. The stimulus drives the strobes low during reset and changes every input on the falling clock edge. It overlaps the two channels only in the directed write-priority case.

// File: rtl/adc_rw_pkg.sv
package adc_rw_pkg;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int INJ_N      = 4;
    localparam int IDX_W      = $clog2(INJ_N);
    localparam int EN_BIT     = 0;
    localparam int ALIGN_BIT  = 11;
    localparam int START_BIT  = 30;
    localparam int RES_LSB    = 24;
    localparam int STAT_W     = 6;
    localparam int OFS_W      = 12;
    localparam int CTLB_VIS_W = 28;
    localparam logic [WORD_W-1:0] THR_HI_RST = 32'h0000_0FFF;

    typedef enum logic [4:0] {
        SEL_STAT, SEL_CTLA, SEL_CTLB, SEL_SMP0, SEL_SMP1, SEL_IOFS,
        SEL_THI, SEL_TLO, SEL_SEQ0, SEL_SEQ1, SEL_SEQ2, SEL_ISEQ,
        SEL_IDAT, SEL_DAT, SEL_NONE
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic [WORD_W-1:0]            stat;
        logic [WORD_W-1:0]            ctla;
        logic [WORD_W-1:0]            ctlb;
        logic [WORD_W-1:0]            smp0;
        logic [WORD_W-1:0]            smp1;
        logic [INJ_N-1:0][WORD_W-1:0] iofs;
        logic [WORD_W-1:0]            thi;
        logic [WORD_W-1:0]            tlo;
        logic [WORD_W-1:0]            seq0;
        logic [WORD_W-1:0]            seq1;
        logic [WORD_W-1:0]            seq2;
        logic [WORD_W-1:0]            iseq;
        logic [INJ_N-1:0][WORD_W-1:0] idat;
        logic [WORD_W-1:0]            dat;
    } regs_t;

    // Word index map; the injected groups are contiguous runs of INJ_N words.
    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t                  d;
        logic [ADDR_W-3:0]     w;
        w     = a[ADDR_W-1:2];
        d.sel = SEL_NONE;
        d.idx = '0;
        if (a[1:0] == 2'b00) begin
            if (w >= 6'd5 && w < 6'd5 + 6'(INJ_N)) begin
                d.sel = SEL_IOFS;
                d.idx = IDX_W'(w - 6'd5);
            end else if (w >= 6'd15 && w < 6'd15 + 6'(INJ_N)) begin
                d.sel = SEL_IDAT;
                d.idx = IDX_W'(w - 6'd15);
            end else begin
                case (w)
                    6'd0:    d.sel = SEL_STAT;
                    6'd1:    d.sel = SEL_CTLA;
                    6'd2:    d.sel = SEL_CTLB;
                    6'd3:    d.sel = SEL_SMP0;
                    6'd4:    d.sel = SEL_SMP1;
                    6'd9:    d.sel = SEL_THI;
                    6'd10:   d.sel = SEL_TLO;
                    6'd11:   d.sel = SEL_SEQ0;
                    6'd12:   d.sel = SEL_SEQ1;
                    6'd13:   d.sel = SEL_SEQ2;
                    6'd14:   d.sel = SEL_ISEQ;
                    6'd19:   d.sel = SEL_DAT;
                    default: d.sel = SEL_NONE;
                endcase
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/adc_sample_gen.sv
module adc_sample_gen
    import adc_rw_pkg::*;
#(
    parameter int STEP = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cur,
    input  logic [1:0]        res,
    input  logic              align,
    input  logic              fire,
    output logic [WORD_W-1:0] nxt,
    output logic [WORD_W-1:0] view
);
    localparam logic [WORD_W-1:0] ALIGN_MASK = 32'h0000_FFF0;

    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] sum;

    always_comb begin
        case (res)
            2'd0:    mask = 32'h0000_0FFF;
            2'd1:    mask = 32'h0000_03FF;
            2'd2:    mask = 32'h0000_00FF;
            default: mask = 32'h0000_003F;
        endcase
        sum  = cur + WORD_W'(STEP);
        nxt  = sum & mask;
        view = align ? ((nxt << 1) & ALIGN_MASK) : nxt;
    end

    AST_SAMPLE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((cur & ~$past(mask)) == '0)); // R4
endmodule

// File: rtl/adc_rd_mux.sv
module adc_rd_mux
    import adc_rw_pkg::*;
(
    input  regs_t             r,
    input  dec_t              d,
    input  logic              fire,
    input  logic [WORD_W-1:0] view,
    output logic [WORD_W-1:0] data
);
    always_comb begin
        case (d.sel)
            SEL_STAT: data = r.stat;
            SEL_CTLA: data = r.ctla;
            SEL_CTLB: data = {{(WORD_W-CTLB_VIS_W){1'b0}}, r.ctlb[CTLB_VIS_W-1:0]};
            SEL_SMP0: data = r.smp0;
            SEL_SMP1: data = r.smp1;
            SEL_IOFS: data = r.iofs[d.idx];
            SEL_THI:  data = r.thi;
            SEL_TLO:  data = r.tlo;
            SEL_SEQ0: data = r.seq0;
            SEL_SEQ1: data = r.seq1;
            SEL_SEQ2: data = r.seq2;
            SEL_ISEQ: data = r.iseq;
            SEL_IDAT: data = r.idat[d.idx] - r.iofs[d.idx];
            SEL_DAT:  data = fire ? view : '0;
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/adc_reg_window.sv
module adc_reg_window
    import adc_rw_pkg::*;
#(
    parameter int SAMPLE_STEP = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data
);
    localparam regs_t RST_VAL = '{thi: THR_HI_RST, default: '0};

    regs_t             r_d, r_q;
    dec_t              rdec, wdec;
    logic              fire;
    logic [WORD_W-1:0] smp_nxt, smp_view, rd_word;

    assign rdec = decode(rd_addr);
    assign wdec = decode(wr_addr);
    assign fire = rd_en && (rdec.sel == SEL_DAT)
                  && r_q.ctlb[EN_BIT] && r_q.ctlb[START_BIT];

    adc_sample_gen #(.STEP(SAMPLE_STEP)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (r_q.dat),
        .res   (r_q.ctla[RES_LSB+1:RES_LSB]),
        .align (r_q.ctlb[ALIGN_BIT]),
        .fire  (fire),
        .nxt   (smp_nxt),
        .view  (smp_view)
    );

    adc_rd_mux u_mux (
        .r    (r_q),
        .d    (rdec),
        .fire (fire),
        .view (smp_view),
        .data (rd_word)
    );

    assign rd_data = rd_en ? rd_word : '0;

    always_comb begin
        r_d = r_q;
        if (fire) begin
            r_d.dat              = smp_nxt;
            r_d.ctlb[START_BIT]  = 1'b0;
        end
        // bus write comes last so it overrides the trigger clear
        if (wr_en) begin
            case (wdec.sel)
                SEL_STAT: r_d.stat = r_q.stat
                                   & {{(WORD_W-STAT_W){1'b0}}, wr_data[STAT_W-1:0]};
                SEL_CTLA: r_d.ctla = wr_data;
                SEL_CTLB: r_d.ctlb = wr_data;
                SEL_SMP0: r_d.smp0 = wr_data;
                SEL_SMP1: r_d.smp1 = wr_data;
                SEL_IOFS: r_d.iofs[wdec.idx] = {{(WORD_W-OFS_W){1'b0}}, wr_data[OFS_W-1:0]};
                SEL_THI:  r_d.thi  = wr_data;
                SEL_TLO:  r_d.tlo  = wr_data;
                SEL_SEQ0: r_d.seq0 = wr_data;
                SEL_SEQ1: r_d.seq1 = wr_data;
                SEL_SEQ2: r_d.seq2 = wr_data;
                SEL_ISEQ: r_d.iseq = wr_data;
                SEL_IDAT: r_d.idat[wdec.idx] = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    AST_RESET_THR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (r_q.thi == THR_HI_RST && r_q.dat == '0)); // R1
    AST_START_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !(wr_en && wdec.sel == SEL_CTLB)) |=> !r_q.ctlb[START_BIT]); // R2
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rdec.sel == SEL_DAT && !fire) |-> (rd_data == '0)); // R3
    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rdec.sel == SEL_DAT && !fire) |=> $stable(r_q.dat)); // R3
    AST_ALIGN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && r_q.ctlb[ALIGN_BIT]) |-> (rd_data[3:0] == 4'h0 && rd_data[WORD_W-1:16] == '0)); // R5
    AST_STAT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.stat[WORD_W-1:STAT_W] == '0); // R6
    AST_CTLB_TOP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rdec.sel == SEL_CTLB) |-> (rd_data[WORD_W-1:CTLB_VIS_W] == '0)); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rdec.sel == SEL_NONE) |-> (rd_data == '0)); // R10
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdec.sel == SEL_CTLB) |=> (r_q.ctlb == $past(wr_data))); // R11

    for (genvar gi = 0; gi < INJ_N; gi++) begin : g_ofs_chk
        AST_OFS_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
            r_q.iofs[gi][WORD_W-1:OFS_W] == '0); // R8
    end
endmodule

// File: tb/test_adc_reg_window.sv
module test_adc_reg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk; // 250 MHz

    adc_reg_window i_adc_reg_window (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{8'h04, 32'hA5A5_1234, 32'hA5A5_1234}, // R12
        '{8'h08, 32'hF000_0ABC, 32'h0000_0ABC}, // R7
        '{8'h0C, 32'h1234_5678, 32'h1234_5678}, // R12
        '{8'h10, 32'h8765_4321, 32'h8765_4321}, // R12
        '{8'h14, 32'hFFFF_F123, 32'h0000_0123}, // R8
        '{8'h20, 32'h0000_1ABC, 32'h0000_0ABC}, // R8
        '{8'h24, 32'h0000_0800, 32'h0000_0800}, // R12
        '{8'h28, 32'h0000_0100, 32'h0000_0100}, // R12
        '{8'h2C, 32'h0011_2233, 32'h0011_2233}, // R12
        '{8'h30, 32'h4455_6677, 32'h4455_6677}, // R12
        '{8'h34, 32'h8899_AABB, 32'h8899_AABB}, // R12
        '{8'h38, 32'hCCDD_EEFF, 32'hCCDD_EEFF}, // R12
        '{8'h00, 32'hFFFF_FFFF, 32'h0000_0000}, // R6
        '{8'h50, 32'hDEAD_0001, 32'h0000_0000}, // R10
        '{8'hFC, 32'h1111_1111, 32'h0000_0000}, // R10
        '{8'h4C, 32'h0000_0FFF, 32'h0000_0000}  // R10
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 v = rd_data;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic rd_wr(input logic [7:0] ra, input logic [7:0] wa,
                         input logic [31:0] d, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = ra;
        wr_en = 1'b1; wr_addr = wa; wr_data = d;
        #1 v = rd_data;
        @(posedge clk);
        #1 begin rd_en = 1'b0; wr_en = 1'b0; end
    endtask

    function automatic logic [31:0] mask_of(input int res);
        case (res)
            0:       return 32'h0FFF;
            1:       return 32'h03FF;
            2:       return 32'h00FF;
            default: return 32'h003F;
        endcase
    endfunction

    localparam logic [31:0] GO       = 32'h4000_0001;
    localparam logic [31:0] GO_ALIGN = 32'h4000_0801;

    logic [31:0] model = '0;

    // one triggered sample at resolution res with control word B value cb
    task automatic sample(input int res, input logic [31:0] cb, input string tag);
        logic [31:0] v, e;
        wr(8'h08, cb);
        rd(8'h4C, v);
        model = (model + 32'd7) & mask_of(res);
        e = cb[11] ? ((model << 1) & 32'hFFF0) : model;
        check(tag, v, e);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1: reset values
        rd(8'h24, v); check("R1 high threshold", v, 32'h0000_0FFF);
        rd(8'h04, v); check("R1 control A", v, 32'h0);
        rd(8'h3C, v); check("R1 injected data", v, 32'h0);
        rd(8'h2C, v); check("R1 sequence", v, 32'h0);

        // vector table: write then read back
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].a, VEC[i].w);
            rd(VEC[i].a, v);
            check($sformatf("table row %0d addr %h", i, VEC[i].a), v, VEC[i].e);
        end

        do_reset();
        model = '0;

        // R3: idle result reads
        rd(8'h4C, v); check("R3 disabled read", v, 32'h0);
        wr(8'h08, 32'h0000_0001);
        rd(8'h4C, v); check("R3 enable only", v, 32'h0);

        // R2 / R4: 12-bit wraparound
        for (int n = 0; n < 600; n++) sample(0, GO, "R4 12-bit");
        rd(8'h4C, v); check("R2 second read without start", v, 32'h0);
        sample(0, GO, "R3 sample kept after idle read");

        // R10: write to the result word does not disturb it
        wr(8'h4C, 32'h0000_0ABC);
        sample(0, GO, "R10 result write ignored");

        // R4: 10-bit, 8-bit, 6-bit
        wr(8'h04, 32'h0100_0000);
        for (int n = 0; n < 160; n++) sample(1, GO, "R4 10-bit");
        wr(8'h04, 32'h0200_0000);
        for (int n = 0; n < 40; n++) sample(2, GO, "R4 8-bit");
        wr(8'h04, 32'h0300_0000);
        for (int n = 0; n < 12; n++) sample(3, GO, "R4 6-bit");

        // R5: left alignment at 12 and 6 bits
        for (int n = 0; n < 4; n++) sample(3, GO_ALIGN, "R5 aligned 6-bit");
        wr(8'h04, 32'h0000_0000);
        for (int n = 0; n < 8; n++) sample(0, GO_ALIGN, "R5 aligned 12-bit");

        // R11: same-cycle control B write keeps start set
        wr(8'h08, GO);
        rd_wr(8'h4C, 8'h08, GO, v);
        model = (model + 32'd7) & 32'h0FFF;
        check("R11 triggered read", v, model);
        rd(8'h4C, v);
        model = (model + 32'd7) & 32'h0FFF;
        check("R11 start still set", v, model);
        rd(8'h4C, v); check("R2 start consumed", v, 32'h0);

        // R9: injected data minus offset
        wr(8'h18, 32'h0000_0010);
        wr(8'h40, 32'h0000_0005);
        rd(8'h40, v); check("R9 difference wraps", v, 32'hFFFF_FFF5);
        wr(8'h18, 32'h0000_0000);
        wr(8'h40, 32'hDEAD_BEEF);
        rd(8'h40, v); check("R9 full width store", v, 32'hDEAD_BEEF);

        // R10: misaligned offset
        rd(8'h26, v); check("R10 misaligned read", v, 32'h0);
        wr(8'h25, 32'h0000_0000);
        rd(8'h24, v); check("R10 misaligned write ignored", v, 32'h0000_0FFF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule